// File: doc/BRIEF.md
# Video Overlay Source Priority Selector

This block chooses, pixel by pixel, which of three streams reaches the display path: the main video stream, a picture-frame (border) stream, or an on-screen-display RGB stream. Each overlay stream has its own enable and its own per-pixel key that marks the pixel as active. A control input decides which overlay wins when both are active at once. Main video is always the fallback and is shown only where neither enabled overlay is active. The chosen pixel and a 2-bit code naming its source come out one clock after the inputs.

The block also supports the processing around the selection. It raises a flag on the pixels at each boundary between video and picture frame, so that a downstream peaking filter can suppress its transients there. It passes on the black level expander enable only while video is shown. It also switches per pixel between a main and a side bank of contrast, brightness and colour-matrix coefficients for the video path. The bank select is registered, so the bank can change in the middle of a line without glitches.

Top module: `ovl_src_priority`

## Requirements
- R1: While reset is asserted, and for the two clocks after its release, out_src, out_pix, blx_act, pk_sup, adj_contrast, adj_bright and adj_mat are all zero. This holds whatever the inputs are.
- R2: When neither overlay is active (an overlay is active when its enable and its key are both 1), out_pix equals vid_pix and out_src equals 0 one clock later. out_src never takes the value 3.
- R3: When only the picture frame is active, out_pix equals frm_pix and out_src equals 1 one clock later.
- R4: When only the OSD is active, out_pix equals osd_pix and out_src equals 2 one clock later.
- R5: When both overlays are active, osd_over_frm = 1 selects the OSD (code 2) and osd_over_frm = 0 selects the picture frame (code 1).
- R6: A key whose enable is 0 has no effect on the selection.
- R7: With pk_sup_en = 1, pk_sup is high when one of two conditions holds. Either the source code now on out_src and the source code that the present inputs select form a video/frame pair (codes 0 and 1, in either order), or the previous out_src and the present out_src form such a pair. Changes that involve the OSD code do not raise pk_sup. pk_sup follows pk_sup_en and the present inputs within the same cycle.
- R8: With pk_sup_en = 0, pk_sup is 0.
- R9: One clock after a cycle with side_sel = 1, adj_contrast, adj_bright and adj_mat equal that cycle's side-bank inputs. One clock after a cycle with side_sel = 0, they equal the main-bank inputs. Any cycle may switch banks.
- R10: blx_act is 1 one clock after a cycle in which blx_en is 1 and video is selected; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_pix | input | PIX_W | Main video pixel |
| frm_pix | input | PIX_W | Picture-frame pixel |
| osd_pix | input | PIX_W | OSD RGB pixel |
| frm_en | input | 1 | Picture-frame source enable |
| frm_key | input | 1 | Picture-frame pixel active |
| osd_en | input | 1 | OSD source enable |
| osd_key | input | 1 | OSD pixel active |
| osd_over_frm | input | 1 | 1: OSD wins over frame; 0: frame wins |
| pk_sup_en | input | 1 | Enable for the peaking-suppression flag |
| blx_en | input | 1 | Black level expander request |
| side_sel | input | 1 | 1: side bank, 0: main bank |
| main_contrast | input | COEF_W | Main bank contrast |
| main_bright | input | COEF_W | Main bank brightness |
| main_mat | input | MAT_N*COEF_W | Main bank matrix coefficients |
| side_contrast | input | COEF_W | Side bank contrast |
| side_bright | input | COEF_W | Side bank brightness |
| side_mat | input | MAT_N*COEF_W | Side bank matrix coefficients |
| out_pix | output | PIX_W | Selected pixel |
| out_src | output | 2 | Selected source: 0 video, 1 frame, 2 OSD |
| pk_sup | output | 1 | Peaking-suppression flag at video/frame boundaries |
| blx_act | output | 1 | Black level expander enable, video only |
| adj_contrast | output | COEF_W | Active contrast |
| adj_bright | output | COEF_W | Active brightness |
| adj_mat | output | MAT_N*COEF_W | Active matrix coefficients |

## Verification
The bench sweeps all 64 combinations of the two enables, the two keys, the priority bit and the bank select. It visits them in a scrambled order, so that successive pixels change source in many different ways. Cases with both keys set separate the two priority settings. Cases with a key set while its enable is low show whether the enable gates the key. The scrambled order puts every pairing of previous, present and next source next to one another, which shows whether pk_sup fires only around video/frame boundaries and never at OSD edges. A pass with pk_sup_en low confirms that the flag stays off. Bank values and pixels change on every cycle, which exposes any extra or missing register stage on the selected path.

// File: rtl/osp_pkg.sv
package osp_pkg;
  typedef enum logic [1:0] {
    SRC_VID = 2'd0,
    SRC_FRM = 2'd1,
    SRC_OSD = 2'd2
  } osp_src_e;

  // True when the two codes are video and frame, in either order
  function automatic logic vf_pair(input osp_src_e a, input osp_src_e b);
    return ((a == SRC_VID) && (b == SRC_FRM)) || ((a == SRC_FRM) && (b == SRC_VID));
  endfunction
endpackage

// File: rtl/osp_arbiter.sv
module osp_arbiter
  import osp_pkg::*;
(
  input  logic     frm_en,
  input  logic     frm_key,
  input  logic     osd_en,
  input  logic     osd_key,
  input  logic     osd_over_frm,
  output osp_src_e sel
);
  logic frm_act;
  logic osd_act;

  assign frm_act = frm_en & frm_key;
  assign osd_act = osd_en & osd_key;

  always_comb begin
    if (frm_act && osd_act) sel = osd_over_frm ? SRC_OSD : SRC_FRM;
    else if (osd_act)       sel = SRC_OSD;
    else if (frm_act)       sel = SRC_FRM;
    else                    sel = SRC_VID;
  end
endmodule

// File: rtl/osp_bank_mux.sv
module osp_bank_mux #(
  parameter int COEF_W = 8,
  parameter int MAT_N  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    side_sel,
  input  logic [COEF_W-1:0]       main_contrast,
  input  logic [COEF_W-1:0]       main_bright,
  input  logic [MAT_N*COEF_W-1:0] main_mat,
  input  logic [COEF_W-1:0]       side_contrast,
  input  logic [COEF_W-1:0]       side_bright,
  input  logic [MAT_N*COEF_W-1:0] side_mat,
  output logic [COEF_W-1:0]       adj_contrast,
  output logic [COEF_W-1:0]       adj_bright,
  output logic [MAT_N*COEF_W-1:0] adj_mat
);
  logic [COEF_W-1:0] con_d, bri_d;

  always_comb begin
    con_d = side_sel ? side_contrast : main_contrast;
    bri_d = side_sel ? side_bright   : main_bright;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_contrast <= '0;
      adj_bright   <= '0;
    end else begin
      adj_contrast <= con_d;
      adj_bright   <= bri_d;
    end
  end

  // One register slice per matrix coefficient
  for (genvar k = 0; k < MAT_N; k++) begin : g_coef
    logic [COEF_W-1:0] c_d;
    logic [COEF_W-1:0] c_q;
    always_comb c_d = side_sel ? side_mat[k*COEF_W +: COEF_W] : main_mat[k*COEF_W +: COEF_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end
    assign adj_mat[k*COEF_W +: COEF_W] = c_q;
  end
endmodule

// File: rtl/osp_edge_flag.sv
module osp_edge_flag
  import osp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  osp_src_e cur_src,
  input  osp_src_e nxt_src,
  output logic     flag
);
  osp_src_e prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= SRC_VID;
    else        prev_q <= cur_src;
  end

  // Pixel before the boundary (cur vs nxt) and pixel after it (prev vs cur)
  always_comb flag = rst_n & en & (vf_pair(prev_q, cur_src) | vf_pair(cur_src, nxt_src));
endmodule

// File: rtl/ovl_src_priority.sv
module ovl_src_priority
  import osp_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int COEF_W = 8,
  parameter int MAT_N  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PIX_W-1:0]        vid_pix,
  input  logic [PIX_W-1:0]        frm_pix,
  input  logic [PIX_W-1:0]        osd_pix,
  input  logic                    frm_en,
  input  logic                    frm_key,
  input  logic                    osd_en,
  input  logic                    osd_key,
  input  logic                    osd_over_frm,
  input  logic                    pk_sup_en,
  input  logic                    blx_en,
  input  logic                    side_sel,
  input  logic [COEF_W-1:0]       main_contrast,
  input  logic [COEF_W-1:0]       main_bright,
  input  logic [MAT_N*COEF_W-1:0] main_mat,
  input  logic [COEF_W-1:0]       side_contrast,
  input  logic [COEF_W-1:0]       side_bright,
  input  logic [MAT_N*COEF_W-1:0] side_mat,
  output logic [PIX_W-1:0]        out_pix,
  output logic [1:0]              out_src,
  output logic                    pk_sup,
  output logic                    blx_act,
  output logic [COEF_W-1:0]       adj_contrast,
  output logic [COEF_W-1:0]       adj_bright,
  output logic [MAT_N*COEF_W-1:0] adj_mat
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;
  osp_src_e          sel_d;
  osp_src_e          src_q;
  logic [PIX_W-1:0]  pix_d, pix_q;
  logic              blx_d, blx_q;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  osp_arbiter u_arb (
    .frm_en       (frm_en),
    .frm_key      (frm_key),
    .osd_en       (osd_en),
    .osd_key      (osd_key),
    .osd_over_frm (osd_over_frm),
    .sel          (sel_d)
  );

  always_comb begin
    unique case (sel_d)
      SRC_FRM: pix_d = frm_pix;
      SRC_OSD: pix_d = osd_pix;
      default: pix_d = vid_pix;
    endcase
    blx_d = blx_en & (sel_d == SRC_VID);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q <= SRC_VID;
      pix_q <= '0;
      blx_q <= 1'b0;
    end else begin
      src_q <= sel_d;
      pix_q <= pix_d;
      blx_q <= blx_d;
    end
  end

  osp_edge_flag u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (pk_sup_en),
    .cur_src (src_q),
    .nxt_src (sel_d),
    .flag    (pk_sup)
  );

  osp_bank_mux #(.COEF_W(COEF_W), .MAT_N(MAT_N)) u_bank (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .side_sel      (side_sel),
    .main_contrast (main_contrast),
    .main_bright   (main_bright),
    .main_mat      (main_mat),
    .side_contrast (side_contrast),
    .side_bright   (side_bright),
    .side_mat      (side_mat),
    .adj_contrast  (adj_contrast),
    .adj_bright    (adj_bright),
    .adj_mat       (adj_mat)
  );

  assign out_pix = pix_q;
  assign out_src = src_q;
  assign blx_act = blx_q;
endmodule

// File: rtl/osp_checker.sv
module osp_checker #(
  parameter int COEF_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              frm_en,
  input logic              frm_key,
  input logic              osd_en,
  input logic              osd_key,
  input logic              osd_over_frm,
  input logic              pk_sup_en,
  input logic              pk_sup,
  input logic              side_sel,
  input logic [COEF_W-1:0] side_contrast,
  input logic [COEF_W-1:0] adj_contrast,
  input logic              blx_act,
  input logic [1:0]        out_src
);
  logic [1:0] armed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= '0;
    else             armed <= {armed[0], 1'b1};
  end

  // R2
  src_code_chk: assert property (@(posedge clk) disable iff (!armed[1])
    out_src != 2'd3);

  // R3
  frame_only_chk: assert property (@(posedge clk) disable iff (!armed[1])
    $past(frm_en && frm_key && !(osd_en && osd_key)) |-> out_src == 2'd1);

  // R4
  osd_only_chk: assert property (@(posedge clk) disable iff (!armed[1])
    $past(osd_en && osd_key && !(frm_en && frm_key)) |-> out_src == 2'd2);

  // R5
  osd_wins_chk: assert property (@(posedge clk) disable iff (!armed[1])
    $past(frm_en && frm_key && osd_en && osd_key && osd_over_frm) |-> out_src == 2'd2);

  // R5
  frame_wins_chk: assert property (@(posedge clk) disable iff (!armed[1])
    $past(frm_en && frm_key && osd_en && osd_key && !osd_over_frm) |-> out_src == 2'd1);

  // R6
  gated_key_chk: assert property (@(posedge clk) disable iff (!armed[1])
    $past(!(frm_en && frm_key) && !(osd_en && osd_key)) |-> out_src == 2'd0);

  // R8
  pk_off_chk: assert property (@(posedge clk) disable iff (!armed[1])
    !pk_sup_en |-> !pk_sup);

  // R9
  side_bank_chk: assert property (@(posedge clk) disable iff (!armed[1])
    $past(side_sel) |-> adj_contrast == $past(side_contrast));

  // R10
  blx_video_chk: assert property (@(posedge clk) disable iff (!armed[1])
    blx_act |-> out_src == 2'd0);
endmodule

bind ovl_src_priority osp_checker #(.COEF_W(COEF_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .frm_en        (frm_en),
  .frm_key       (frm_key),
  .osd_en        (osd_en),
  .osd_key       (osd_key),
  .osd_over_frm  (osd_over_frm),
  .pk_sup_en     (pk_sup_en),
  .pk_sup        (pk_sup),
  .side_sel      (side_sel),
  .side_contrast (side_contrast),
  .adj_contrast  (adj_contrast),
  .blx_act       (blx_act),
  .out_src       (out_src)
);

// File: tb/ovl_src_priority_bench.sv
`timescale 1ns/1ps
module ovl_src_priority_bench;
  localparam int PW = 24;
  localparam int CW = 8;
  localparam int MN = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic [PW-1:0] vid_pix, frm_pix, osd_pix;
  logic frm_en, frm_key, osd_en, osd_key, osd_over_frm, pk_sup_en, blx_en, side_sel;
  logic [CW-1:0] main_contrast, main_bright, side_contrast, side_bright;
  logic [MN*CW-1:0] main_mat, side_mat;
  logic [PW-1:0] out_pix;
  logic [1:0] out_src;
  logic pk_sup, blx_act;
  logic [CW-1:0] adj_contrast, adj_bright;
  logic [MN*CW-1:0] adj_mat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ovl_src_priority #(.PIX_W(PW), .COEF_W(CW), .MAT_N(MN)) u_ovl_src_priority (
    .clk(clk), .rst_n(rst_n), .vid_pix(vid_pix), .frm_pix(frm_pix), .osd_pix(osd_pix),
    .frm_en(frm_en), .frm_key(frm_key), .osd_en(osd_en), .osd_key(osd_key),
    .osd_over_frm(osd_over_frm), .pk_sup_en(pk_sup_en), .blx_en(blx_en), .side_sel(side_sel),
    .main_contrast(main_contrast), .main_bright(main_bright), .main_mat(main_mat),
    .side_contrast(side_contrast), .side_bright(side_bright), .side_mat(side_mat),
    .out_pix(out_pix), .out_src(out_src), .pk_sup(pk_sup), .blx_act(blx_act),
    .adj_contrast(adj_contrast), .adj_bright(adj_bright), .adj_mat(adj_mat)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_sel(input logic fe, fk, oe, ok, ovr);
    logic fa, oa;
    fa = fe & fk;
    oa = oe & ok;
    if (fa && oa) return ovr ? 2'd2 : 2'd1;
    if (oa) return 2'd2;
    if (fa) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic vf(input logic [1:0] a, input logic [1:0] b);
    return (a == 2'd0 && b == 2'd1) || (a == 2'd1 && b == 2'd0);
  endfunction

  task automatic drive_idle();
    {frm_en, frm_key, osd_en, osd_key, osd_over_frm, pk_sup_en, blx_en, side_sel} = '0;
    vid_pix = '0; frm_pix = '0; osd_pix = '0;
    main_contrast = '0; main_bright = '0; main_mat = '0;
    side_contrast = '0; side_bright = '0; side_mat = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] e_src, e_prev, sel, nsel;
    logic l_fe, l_fk, l_oe, l_ok, l_ovr, l_side, l_blx;
    logic [PW-1:0] l_vid, l_frm, l_osd;
    logic [CW-1:0] l_mc, l_mb, l_sc, l_sb;
    logic [MN*CW-1:0] l_mm, l_sm;
    logic [PW-1:0] e_pix;
    string tag;
    int cnt;

    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: tempting inputs while in reset
    frm_en = 1; frm_key = 1; pk_sup_en = 1; blx_en = 1; side_sel = 1;
    side_contrast = 8'h5a; side_bright = 8'h33; side_mat = {MN{8'h77}}; frm_pix = 24'hABCDEF;
    @(negedge clk);
    chk("R1 out_src", out_src, 0);
    chk("R1 out_pix", out_pix, 0);
    chk("R1 pk_sup", pk_sup, 0);
    chk("R1 blx_act", blx_act, 0);
    chk("R1 adj_contrast", adj_contrast, 0);
    chk("R1 adj_bright", adj_bright, 0);
    chk("R1 adj_mat", adj_mat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_src after release", out_src, 0);
    chk("R1 pk_sup after release", pk_sup, 0);
    chk("R1 adj_contrast after release", adj_contrast, 0);
    drive_idle();
    repeat (3) @(negedge clk);

    e_src = 0; e_prev = 0; cnt = 0;
    {l_fe, l_fk, l_oe, l_ok, l_ovr, l_side, l_blx} = '0;
    l_vid = '0; l_frm = '0; l_osd = '0;
    l_mc = '0; l_mb = '0; l_sc = '0; l_sb = '0; l_mm = '0; l_sm = '0;

    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 65; i++) begin
        logic [5:0] idx;
        @(negedge clk);
        // Registered outputs from the previously applied inputs
        sel = model_sel(l_fe, l_fk, l_oe, l_ok, l_ovr);
        e_prev = e_src;
        e_src = sel;
        e_pix = (sel == 2'd1) ? l_frm : (sel == 2'd2) ? l_osd : l_vid;
        if ((l_fe & l_fk) && (l_oe & l_ok)) tag = "R5";
        else if (sel == 2'd1) tag = "R3";
        else if (sel == 2'd2) tag = "R4";
        else if ((l_fk & !l_fe) || (l_ok & !l_oe)) tag = "R6";
        else tag = "R2";
        chk({tag, " out_src"}, out_src, sel);
        chk({tag, " out_pix"}, out_pix, e_pix);
        chk("R10 blx_act", blx_act, l_blx & (sel == 2'd0));
        chk("R9 adj_contrast", adj_contrast, l_side ? l_sc : l_mc);
        chk("R9 adj_bright", adj_bright, l_side ? l_sb : l_mb);
        chk("R9 adj_mat", adj_mat, l_side ? l_sm : l_mm);

        // New stimulus
        idx = 6'((i * 37 + pass * 11) % 64);
        frm_en = idx[0]; frm_key = idx[1]; osd_en = idx[2]; osd_key = idx[3];
        osd_over_frm = idx[4]; side_sel = idx[5];
        blx_en = idx[1] ^ idx[3] ^ pass[0];
        pk_sup_en = (pass != 2);
        vid_pix = 24'h100000 + PW'(cnt);
        frm_pix = 24'h200000 + PW'(cnt * 3);
        osd_pix = 24'h400000 + PW'(cnt * 7);
        main_contrast = CW'(cnt);
        side_contrast = ~CW'(cnt);
        main_bright = CW'(cnt * 3);
        side_bright = CW'(cnt * 5 + 1);
        main_mat = {MN{CW'(cnt + 1)}} ^ MN*CW'(cnt);
        side_mat = {MN{CW'(cnt + 8'h40)}};
        l_fe = frm_en; l_fk = frm_key; l_oe = osd_en; l_ok = osd_key; l_ovr = osd_over_frm;
        l_side = side_sel; l_blx = blx_en;
        l_vid = vid_pix; l_frm = frm_pix; l_osd = osd_pix;
        l_mc = main_contrast; l_sc = side_contrast; l_mb = main_bright; l_sb = side_bright;
        l_mm = main_mat; l_sm = side_mat;
        cnt++;

        #1;
        nsel = model_sel(frm_en, frm_key, osd_en, osd_key, osd_over_frm);
        if (pk_sup_en)
          chk("R7 pk_sup", pk_sup, vf(e_prev, e_src) | vf(e_src, nsel));
        else
          chk("R8 pk_sup", pk_sup, 0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule